// File: doc/BRIEF.md
# Bidirectional Host/Slave Interrupt Unit

This block carries interrupt requests in both directions between a bus host and a slave core, behind a small byte-addressed register port. On the host-bound side, the slave core raises any of eight sources with single-cycle pulses. Each pulse sets a sticky pending bit. The host reads the pending bits, clears them by writing ones, and chooses with an enable mask which sources may pull its interrupt line. That line is active-low and level-sensitive. It stays low while at least one bit is both pending and enabled.

On the slave-bound side, the host writes an eight-bit doorbell register. Every bit that goes from 0 to 1 in that write raises a one-cycle interrupt pulse toward the slave core, together with a vector saying which bits fired. The doorbell register then clears itself, so the host can ring the same bit again later without first writing a zero.

Register offsets, the address width and the number of sources are parameters. The defaults put pending status at 0x058, the clear port at 0x0D4, the enable mask at 0x0DC and the doorbell at 0x08D.

Top module: `dual_irq_unit`

## Requirements
- R1: After synchronous active-low reset, the pending status, the enable mask and the doorbell register all read 0, `host_irq_n` is 1, `slv_irq` is 0 and `slv_irq_vec` is 0.
- R2: A 1 on bit i of `src_pulse` at a clock edge sets pending bit i, which reads as bit i at offset 0x058 from the next cycle on. Pending bits latch whether or not they are enabled. Writes to offset 0x058 leave the pending bits unchanged.
- R3: A write to offset 0x0D4 clears every pending bit whose `bus_wdata` bit is 1. Bits written as 0 keep their value. A read of offset 0x0D4 returns 0.
- R4: A write to offset 0x0DC loads the enable mask, bit i enabling source i. A read of that offset returns the mask.
- R5: `host_irq_n` is 0 exactly when (pending AND mask) is nonzero, evaluated on the register values after each clock edge. Enabling an already pending source therefore drives the line low in the cycle after the mask write.
- R6: When bit i of `src_pulse` and a clear write with bit i = 1 arrive at the same edge, pending bit i ends up set.
- R7: A write of value W to offset 0x08D, while the doorbell holds D, makes `slv_irq_vec` equal W AND NOT D for exactly the next cycle, with `slv_irq` = 1 when that vector is nonzero. Both outputs are 0 in any cycle that does not follow a doorbell write.
- R8: The doorbell reads W in the cycle after a write of W and clears itself to 0 after the next edge without a doorbell write. A second doorbell write at that next edge replaces the content with the new value instead.
- R9: `bus_rdata` is combinational from `bus_addr`, and any offset other than 0x058 and 0x0DC returns 0, except 0x08D, which returns the doorbell register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (12) | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | NSRC (8) | Write data |
| bus_rdata | output | NSRC (8) | Read data for `bus_addr` |
| src_pulse | input | NSRC (8) | Slave-side source pulses toward the host |
| host_irq_n | output | 1 | Active-low level interrupt toward the host |
| slv_irq | output | 1 | One-cycle interrupt toward the slave core |
| slv_irq_vec | output | NSRC (8) | Doorbell bits that fired in this pulse |

## Verification
The bench builds the block with its defaults: eight sources and a 12-bit address. At that size all 256 enable-mask values can be swept, each paired with a computed pending pattern and clear pattern, so every mask/pending combination class reaches the line check. All 256 doorbell values are written back to back against a second computed value, which exercises the 0-to-1 filter against a nonzero previous content and the self-clear. The same-edge set/clear race, unmasking of a pending source, read-only status and unmapped reads are driven directly.

// File: rtl/dual_irq_pkg.sv
// Shared types for the bidirectional interrupt unit.
// Assumes one register access per cycle; read selection is purely combinational.
package dual_irq_pkg;

    // Write strobes produced by the register decoder.
    typedef struct packed {
        logic clr;
        logic mask;
        logic bell;
    } wr_stb_t;

    // Which register drives the read data.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2,
        SEL_BELL = 2'd3
    } rd_sel_t;

endpackage

// File: rtl/irq_reg_decode.sv
// Address decoder: turns a byte offset and a write strobe into per-register
// write strobes and a read selector. Assumes offsets are distinct.
module irq_reg_decode #(
    parameter int ADDR_W   = 12,
    parameter int STAT_OFS = 'h058,
    parameter int CLR_OFS  = 'h0D4,
    parameter int MASK_OFS = 'h0DC,
    parameter int BELL_OFS = 'h08D
) (
    input  logic                     [ADDR_W-1:0] addr,
    input  logic                                  wr,
    output dual_irq_pkg::wr_stb_t                 stb,
    output dual_irq_pkg::rd_sel_t                 sel
);
    import dual_irq_pkg::*;

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_OFS);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] A_BELL = ADDR_W'(BELL_OFS);

    // Write strobes: only registers with side effects get one.
    always_comb begin
        stb.clr  = wr && (addr == A_CLR);
        stb.mask = wr && (addr == A_MASK);
        stb.bell = wr && (addr == A_BELL);
    end

    // Read selector; the clear port and unmapped offsets read as zero.
    always_comb begin
        if (addr == A_STAT)      sel = SEL_STAT;
        else if (addr == A_MASK) sel = SEL_MASK;
        else if (addr == A_BELL) sel = SEL_BELL;
        else                     sel = SEL_NONE;
    end

endmodule

// File: rtl/host_irq_ctrl.sv
// Host-bound interrupt side: sticky pending bits set by source pulses,
// write-one-to-clear, enable mask and an active-low level line.
// Assumes a set and a clear of the same bit at one edge resolve to set.
module host_irq_ctrl #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_pulse,
    input  logic            clr_we,
    input  logic            mask_we,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] pend_q,
    output logic [NSRC-1:0] mask_q,
    output logic            irq_n
);

    // One sticky pending flop per source; the set term dominates the clear.
    for (genvar i = 0; i < NSRC; i++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n)            pend_q[i] <= 1'b0;
            else if (src_pulse[i]) pend_q[i] <= 1'b1;
            else if (clr_we && wdata[i]) pend_q[i] <= 1'b0;
        end
    end

    // Enable mask register, loaded whole by a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // Level line: low while any enabled source is pending.
    always_comb irq_n = ~|(pend_q & mask_q);

endmodule

// File: rtl/doorbell_reg.sv
// Slave-bound doorbell: a host-written register whose 0-to-1 bits fire a
// one-cycle pulse and vector, after which the register clears itself.
// Assumes the rising test compares against the content before the write.
module doorbell_reg #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] bell_q,
    output logic [NSRC-1:0] fire_vec,
    output logic            fire
);

    // Register content: written value for one cycle, then self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)  bell_q <= '0;
        else if (we) bell_q <= wdata;
        else         bell_q <= '0;
    end

    // Registered pulse of the bits that rose with this write.
    always_ff @(posedge clk) begin
        if (!rst_n)  fire_vec <= '0;
        else if (we) fire_vec <= wdata & ~bell_q;
        else         fire_vec <= '0;
    end

    // Summary pulse toward the slave core.
    always_comb fire = |fire_vec;

endmodule

// File: rtl/dual_irq_unit.sv
// Top of the bidirectional interrupt unit: register decode, host-bound
// pending/mask/line logic and the slave-bound doorbell.
// Assumes NSRC <= 8 so every register fits in one byte.
module dual_irq_unit #(
    parameter int NSRC     = 8,
    parameter int ADDR_W   = 12,
    parameter int STAT_OFS = 'h058,
    parameter int CLR_OFS  = 'h0D4,
    parameter int MASK_OFS = 'h0DC,
    parameter int BELL_OFS = 'h08D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   src_pulse,
    output logic              host_irq_n,
    output logic              slv_irq,
    output logic [NSRC-1:0]   slv_irq_vec
);
    import dual_irq_pkg::*;

    wr_stb_t         stb;
    rd_sel_t         sel;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] bell_q;

    irq_reg_decode #(
        .ADDR_W  (ADDR_W),
        .STAT_OFS(STAT_OFS),
        .CLR_OFS (CLR_OFS),
        .MASK_OFS(MASK_OFS),
        .BELL_OFS(BELL_OFS)
    ) u_dec (
        .addr(bus_addr),
        .wr  (bus_wr),
        .stb (stb),
        .sel (sel)
    );

    host_irq_ctrl #(.NSRC(NSRC)) u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_pulse(src_pulse),
        .clr_we   (stb.clr),
        .mask_we  (stb.mask),
        .wdata    (bus_wdata),
        .pend_q   (pend_q),
        .mask_q   (mask_q),
        .irq_n    (host_irq_n)
    );

    doorbell_reg #(.NSRC(NSRC)) u_bell (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (stb.bell),
        .wdata   (bus_wdata),
        .bell_q  (bell_q),
        .fire_vec(slv_irq_vec),
        .fire    (slv_irq)
    );

    // Read multiplexer selected by the decoder.
    always_comb begin
        case (sel)
            SEL_STAT: bus_rdata = pend_q;
            SEL_MASK: bus_rdata = mask_q;
            SEL_BELL: bus_rdata = bell_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dual_irq_unit_chk.sv
// Assertion checker for dual_irq_unit, attached by bind below.
module dual_irq_unit_chk #(
    parameter int NSRC     = 8,
    parameter int ADDR_W   = 12,
    parameter int CLR_OFS  = 'h0D4,
    parameter int MASK_OFS = 'h0DC,
    parameter int BELL_OFS = 'h08D
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [NSRC-1:0]   bus_wdata,
    input logic [NSRC-1:0]   src_pulse,
    input logic              host_irq_n,
    input logic              slv_irq,
    input logic [NSRC-1:0]   slv_irq_vec,
    input logic [NSRC-1:0]   pend_q,
    input logic [NSRC-1:0]   mask_q,
    input logic [NSRC-1:0]   bell_q
);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_OFS);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] A_BELL = ADDR_W'(BELL_OFS);

    // R2 and R6: a pulsed source is pending after the edge, clear or not.
    p_set_latches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse) |=> ((pend_q & $past(src_pulse)) == $past(src_pulse)));

    // R3: cleared bits without a simultaneous pulse are gone.
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLR)
        |=> ((pend_q & $past(bus_wdata) & ~$past(src_pulse)) == '0));

    // R4: mask write loads the mask.
    p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MASK) |=> (mask_q == $past(bus_wdata)));

    // R5: an enabled source pulse pulls the line low on the next cycle.
    p_line_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_pulse & mask_q) && !(bus_wr && bus_addr == A_MASK))
        |=> !host_irq_n);

    // R7: no doorbell pulse without a doorbell write one edge earlier.
    p_bell_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_BELL) |=> (slv_irq_vec == '0 && !slv_irq));

    // R7: a doorbell write fires only bits that rose.
    p_bell_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_BELL)
        |=> (slv_irq_vec == ($past(bus_wdata) & ~$past(bell_q))));

    // R8: the doorbell clears itself after an edge with no write.
    p_bell_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_BELL) |=> (bell_q == '0));

endmodule

bind dual_irq_unit dual_irq_unit_chk #(
    .NSRC    (NSRC),
    .ADDR_W  (ADDR_W),
    .CLR_OFS (CLR_OFS),
    .MASK_OFS(MASK_OFS),
    .BELL_OFS(BELL_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .src_pulse  (src_pulse),
    .host_irq_n (host_irq_n),
    .slv_irq    (slv_irq),
    .slv_irq_vec(slv_irq_vec),
    .pend_q     (pend_q),
    .mask_q     (mask_q),
    .bell_q     (bell_q)
);

// File: tb/dual_irq_unit_bench.sv
// Self-checking bench: sweeps all mask and doorbell values at default size.
module dual_irq_unit_bench;
    localparam int ADDR_W = 12;
    localparam logic [11:0] O_STAT = 12'h058;
    localparam logic [11:0] O_CLR  = 12'h0D4;
    localparam logic [11:0] O_MASK = 12'h0DC;
    localparam logic [11:0] O_BELL = 12'h08D;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [7:0]        src_pulse = '0;
    logic              host_irq_n;
    logic              slv_irq;
    logic [7:0]        slv_irq_vec;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dual_irq_unit u_dual_irq_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pulse(src_pulse),
        .host_irq_n(host_irq_n), .slv_irq(slv_irq), .slv_irq_vec(slv_irq_vec)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] p);
        @(negedge clk);
        src_pulse = p;
        @(negedge clk);
        src_pulse = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(O_STAT, v); chk("R1 status", v, 8'h00);
        rd(O_MASK, v); chk("R1 mask", v, 8'h00);
        rd(O_BELL, v); chk("R1 doorbell", v, 8'h00);
        chk("R1 host line", {7'd0, host_irq_n}, 8'h01);
        chk("R1 slave pulse", {7'd0, slv_irq}, 8'h00);
        chk("R1 slave vector", slv_irq_vec, 8'h00);

        // Host side sweep over every mask value
        for (int m = 0; m < 256; m++) begin
            logic [7:0] p, c;
            p = 8'((m * 37 + 11) & 255);
            c = 8'(m) ^ 8'h5A;
            wr(O_CLR, 8'hFF);
            rd(O_STAT, v); chk("R3 full clear", v, 8'h00);
            wr(O_MASK, 8'(m));
            rd(O_MASK, v); chk("R4 mask readback", v, 8'(m));
            pulse(p);
            rd(O_STAT, v); chk("R2 latch", v, p);
            chk("R5 line after set", {7'd0, host_irq_n}, {7'd0, ((p & 8'(m)) == 8'h00)});
            wr(O_STAT, ~p);
            rd(O_STAT, v); chk("R2 status read-only", v, p);
            wr(O_CLR, c);
            rd(O_STAT, v); chk("R3 partial clear", v, p & ~c);
            chk("R5 line after clear", {7'd0, host_irq_n},
                {7'd0, ((p & ~c & 8'(m)) == 8'h00)});
            rd(O_CLR, v); chk("R3 clear port reads 0", v, 8'h00);
        end

        // R5 unmasking a pending source drives the line at once
        wr(O_CLR, 8'hFF);
        wr(O_MASK, 8'h00);
        pulse(8'h40);
        chk("R5 masked pending line high", {7'd0, host_irq_n}, 8'h01);
        wr(O_MASK, 8'h40);
        chk("R5 unmask line low", {7'd0, host_irq_n}, 8'h00);
        wr(O_MASK, 8'h00);
        chk("R5 remask line high", {7'd0, host_irq_n}, 8'h01);

        // R6 set wins over a same-edge clear
        for (int k = 0; k < 8; k++) begin
            wr(O_CLR, 8'hFF);
            pulse(8'hFF);
            @(negedge clk);
            bus_addr = O_CLR; bus_wdata = 8'hFF; bus_wr = 1'b1;
            src_pulse = 8'(1 << k);
            @(negedge clk);
            bus_wr = 1'b0; src_pulse = '0;
            rd(O_STAT, v); chk("R6 set beats clear", v, 8'(1 << k));
        end

        // R9 unmapped offsets read zero
        wr(O_MASK, 8'hA5);
        rd(12'h100, v); chk("R9 unmapped read", v, 8'h00);
        rd(12'h05C, v); chk("R9 neighbour read", v, 8'h00);

        // Doorbell sweep with back-to-back writes
        for (int a = 0; a < 256; a++) begin
            logic [7:0] b;
            b = 8'((a * 13 + 7) & 255);
            @(negedge clk);
            bus_addr = O_BELL; bus_wdata = 8'(a); bus_wr = 1'b1;
            @(negedge clk);
            chk("R7 first vector", slv_irq_vec, 8'(a));
            chk("R7 first pulse", {7'd0, slv_irq}, {7'd0, (a != 0)});
            chk("R8 holds written", bus_rdata, 8'(a));
            bus_wdata = b;
            @(negedge clk);
            chk("R7 rising only", slv_irq_vec, b & ~8'(a));
            chk("R7 second pulse", {7'd0, slv_irq}, {7'd0, ((b & ~8'(a)) != 8'h00)});
            chk("R8 replaced", bus_rdata, b);
            bus_wr = 1'b0;
            @(negedge clk);
            chk("R7 one-cycle pulse", slv_irq_vec, 8'h00);
            chk("R8 self-clear", bus_rdata, 8'h00);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule